// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block runs one complete mailbox transaction against a byte-addressed mailbox target. A client hands it a command code, a read/write flag and a 32-bit argument through a valid/ready handshake. The block then drives a byte-wide register master port through a fixed sequence. It marks the inbound message as pending, writes the command and argument bytes, and rings the doorbell. It then polls the target's status register until the completion flag appears. For read commands it collects a 32-bit answer from four outbound bytes, and finally it acknowledges the completion flag. The known command codes are 1 (read present power draw), 2 (set power cap), 3 (read power cap) and 4 (read highest allowed cap). The block forwards the code unchanged.

Polling is bounded. The block makes at most `POLL_LIMIT` status reads and holds the port idle for `GAP_CYCLES` clock cycles between two reads, so a silent target ends in a timeout. An error response on any bus access ends the transaction at once. The outcome is reported by a one-cycle done pulse together with a 2-bit result code and the response word.

Top module: `mbx_cmd_seq`

## Requirements
- R1: After reset `start_ready` is 1 and `done` and `bus_req` are 0. A start is taken only when `start_valid` and `start_ready` are both 1. `start_ready` is 1 only while the block is idle, and `bus_req` is 0 whenever `start_ready` is 1. While busy, `start_valid` has no effect.
- R2: The seven writes come first, in this order as (address, data): (0x3F, 0x80), (0x38, command), then the argument bytes from least significant to most significant at 0x39, 0x3A, 0x3B and 0x3C, and last (0x40, 0x01). A request holds its address, data and direction stable until `bus_ack`.
- R3: The status register at 0x02 is then read until its bit 1 reads as 1. After each read that sees bit 1 clear and is not the last allowed read, `bus_req` stays 0 for exactly `GAP_CYCLES` cycles before the next status read.
- R4: If `POLL_LIMIT` status reads all see bit 1 clear, the block makes no further access and finishes with `err_code` = 2 (timeout).
- R5: For read commands (`cmd_is_read` = 1), after the flag is seen the block reads 0x31, 0x32, 0x33 and 0x34 in that order. Byte i lands in `resp_data` bits 8i+7..8i. For write commands these reads do not happen and `resp_data` is 0.
- R6: The final access writes the last status value read, with bit 1 set, to 0x02. A transaction that completes this write without error finishes with `err_code` = 0.
- R7: A bus access acknowledged with `bus_err` = 1 ends the transaction. No further request follows, and the next cycle shows `done` with `err_code` = 1.
- R8: `done` is high for exactly one cycle per transaction. `resp_data` and `err_code` keep their values until the next start is taken.
- R9: A flag first seen on the last allowed status read counts as success. A bus error on that same last read reports 1 (bus error), not 2 (timeout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Client requests a transaction |
| start_ready | output | 1 | Block is idle and takes a start |
| cmd_code | input | 8 | Command code written to inbound byte 0 |
| cmd_is_read | input | 1 | 1: gather a 32-bit response |
| cmd_arg | input | 32 | Argument written to inbound bytes 1..4 |
| done | output | 1 | One-cycle completion pulse |
| resp_data | output | 32 | Response word (read commands) |
| err_code | output | 2 | 0 ok, 1 bus error, 2 timeout |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Register offset |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Access complete this cycle |
| bus_err | input | 1 | Access failed (valid with bus_ack) |
| bus_rdata | input | 8 | Read byte (valid with bus_ack) |

## Verification
On the last allowed status read, the poll-limit check and the bus-error abort can fall in the same cycle. If the flag is present on that read, so can poll success. The bench uses a target that keeps the flag clear until a chosen read and injects an error on a chosen access number. This puts the flag on the eleventh read, puts a bus error on the eleventh read of a silent target, and also runs a plain timeout. In each case a scoreboard compares the exact list of accesses and the reported result code against the expected outcome of R4, R7 and R9.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_POLL, ST_GAP, ST_GATHER, ST_CLEAR, ST_DONE
  } seq_state_t;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_BUS     = 2'd1;
  localparam logic [1:0] RES_TIMEOUT = 2'd2;

  localparam logic [7:0] REG_STATUS   = 8'h02;
  localparam logic [7:0] REG_OUT_BASE = 8'h30;
  localparam logic [7:0] REG_IN_BASE  = 8'h38;
  localparam logic [7:0] REG_IN_TOP   = 8'h3F;
  localparam logic [7:0] REG_KICK     = 8'h40;
  localparam logic [7:0] PENDING_MARK = 8'h80;
  localparam logic [7:0] KICK_VALUE   = 8'h01;
  localparam int         ALERT_BIT    = 1;
  localparam int         NUM_WRITES   = 7;

  // Address of write step idx (0..6)
  function automatic logic [7:0] step_addr(input logic [2:0] idx);
    case (idx)
      3'd0:    return REG_IN_TOP;
      3'd1:    return REG_IN_BASE;
      3'd6:    return REG_KICK;
      default: return REG_IN_BASE + {5'd0, idx} - 8'd1;
    endcase
  endfunction

  // Data byte of write step idx
  function automatic logic [7:0] step_data(input logic [2:0] idx,
                                           input logic [7:0] cmd,
                                           input logic [31:0] arg);
    logic [2:0]  lane;
    logic [31:0] shifted;
    lane    = idx - 3'd2;
    shifted = arg >> {lane, 3'b000};
    case (idx)
      3'd0:    return PENDING_MARK;
      3'd1:    return cmd;
      3'd6:    return KICK_VALUE;
      default: return shifted[7:0];
    endcase
  endfunction

  // Drop byte b into lane idx of word
  function automatic logic [31:0] place_byte(input logic [31:0] word,
                                             input logic [1:0] idx,
                                             input logic [7:0] b);
    logic [31:0] mask;
    mask = 32'hFF << {idx, 3'b000};
    return (word & ~mask) | ({24'd0, b} << {idx, 3'b000});
  endfunction

  function automatic logic [7:0] ack_value(input logic [7:0] stat);
    return stat | (8'd1 << ALERT_BIT);
  endfunction

endpackage

// File: rtl/mbx_gap_timer.sv
module mbx_gap_timer #(
  parameter int CYCLES = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= CW'(CYCLES - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expired = active && (cnt == '0);

  assert_gap_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load |=> !expired);

endmodule

// File: rtl/mbx_poll_tally.sv
module mbx_poll_tally #(
  parameter int LIMIT = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic final_read
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (bump)  count <= count + 1'b1;
  end

  assign final_read = (count == CW'(LIMIT - 1));

  assert_poll_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count < CW'(LIMIT));

endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq
  import mbx_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 7500,
  parameter int POLL_LIMIT = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_valid,
  output logic        start_ready,
  input  logic [7:0]  cmd_code,
  input  logic        cmd_is_read,
  input  logic [31:0] cmd_arg,
  output logic        done,
  output logic [31:0] resp_data,
  output logic [1:0]  err_code,
  output logic        bus_req,
  output logic        bus_we,
  output logic [7:0]  bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic        bus_ack,
  input  logic        bus_err,
  input  logic [7:0]  bus_rdata
);
  localparam logic [2:0] LAST_WRITE = 3'(NUM_WRITES - 1);

  seq_state_t  state;
  logic [2:0]  step;
  logic [7:0]  cmd_q;
  logic [31:0] arg_q;
  logic        rd_q;
  logic [7:0]  stat_q;
  logic [31:0] resp_q;
  logic [1:0]  res_q;

  // Named events
  wire start_fire  = start_valid && start_ready;
  wire xfer_done   = bus_req && bus_ack;
  wire bus_fault   = xfer_done && bus_err;
  wire xfer_ok     = xfer_done && !bus_err;
  wire flag_seen   = bus_rdata[ALERT_BIT];
  wire poll_hit    = (state == ST_POLL) && xfer_ok && flag_seen;
  wire poll_miss   = (state == ST_POLL) && xfer_ok && !flag_seen;
  wire poll_final;
  wire gap_load    = poll_miss && !poll_final;
  wire poll_expire = poll_miss && poll_final;
  wire gap_over;

  mbx_poll_tally #(.LIMIT(POLL_LIMIT)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(start_fire), .bump(gap_load),
    .final_read(poll_final));

  mbx_gap_timer #(.CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .expired(gap_over));

  // Register port drive
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      ST_WRITE: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = step_addr(step);
        bus_wdata = step_data(step, cmd_q, arg_q);
      end
      ST_POLL: begin
        bus_req  = 1'b1;
        bus_addr = REG_STATUS;
      end
      ST_GATHER: begin
        bus_req  = 1'b1;
        bus_addr = REG_OUT_BASE + 8'd1 + {5'd0, step};
      end
      ST_CLEAR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = REG_STATUS;
        bus_wdata = ack_value(stat_q);
      end
      default: ;
    endcase
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      step   <= '0;
      cmd_q  <= '0;
      arg_q  <= '0;
      rd_q   <= 1'b0;
      stat_q <= '0;
      resp_q <= '0;
      res_q  <= RES_OK;
    end else if (bus_fault) begin
      res_q <= RES_BUS;
      state <= ST_DONE;
    end else begin
      case (state)
        ST_IDLE: if (start_fire) begin
          cmd_q  <= cmd_code;
          arg_q  <= cmd_arg;
          rd_q   <= cmd_is_read;
          resp_q <= '0;
          res_q  <= RES_OK;
          step   <= '0;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (xfer_ok) begin
          if (step == LAST_WRITE) state <= ST_POLL;
          step <= (step == LAST_WRITE) ? 3'd0 : step + 3'd1;
        end
        ST_POLL: if (xfer_ok) begin
          stat_q <= bus_rdata;
          if (poll_hit)         state <= rd_q ? ST_GATHER : ST_CLEAR;
          else if (poll_expire) begin
            res_q <= RES_TIMEOUT;
            state <= ST_DONE;
          end else              state <= ST_GAP;
        end
        ST_GAP: if (gap_over) state <= ST_POLL;
        ST_GATHER: if (xfer_ok) begin
          resp_q <= place_byte(resp_q, step[1:0], bus_rdata);
          if (step == 3'd3) begin
            step  <= '0;
            state <= ST_CLEAR;
          end else step <= step + 3'd1;
        end
        ST_CLEAR: if (xfer_ok) begin
          res_q <= RES_OK;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign start_ready = (state == ST_IDLE);
  assign done        = (state == ST_DONE);
  assign resp_data   = resp_q;
  assign err_code    = res_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !bus_req);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  assert_gap_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_load |=> !bus_req);
  assert_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expire |=> done && err_code == RES_TIMEOUT);
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |=> done && err_code == RES_BUS && !bus_req);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready && !start_valid |=> $stable(resp_data) && $stable(err_code));

endmodule

// File: tb/mbx_cmd_seq_test.sv
module mbx_cmd_seq_test;

  localparam int GAP   = 4;
  localparam int LIMIT = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [7:0]  cmd_code = '0;
  logic        cmd_is_read = 1'b0;
  logic [31:0] cmd_arg = '0;
  logic        done;
  logic [31:0] resp_data;
  logic [1:0]  err_code;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;
  logic [7:0]  bus_rdata = '0;

  always #5 clk = ~clk;

  mbx_cmd_seq #(.GAP_CYCLES(GAP), .POLL_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .cmd_code(cmd_code), .cmd_is_read(cmd_is_read), .cmd_arg(cmd_arg),
    .done(done), .resp_data(resp_data), .err_code(err_code),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata));

  typedef struct packed { logic [7:0] addr; logic we; logic [7:0] data; } acc_t;
  typedef struct packed { logic [1:0] err; logic chk_data; logic [31:0] data; } res_t;

  acc_t acc_q[$];
  res_t res_q[$];

  int tests = 0;
  int fails = 0;

  // target model configuration
  int          cfg_ready_after = 0;
  int          cfg_err_at = -1;
  int          cfg_lat = 0;
  logic [31:0] cfg_resp = '0;
  int          acc_idx = 0;
  int          poll_seen = 0;
  int          lat_cnt = 0;
  bit          gap_on = 0;
  int          gap_cnt = 0;
  bit          prev_done = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // target responder and access monitor
  always @(negedge clk) begin
    if (gap_on) begin
      if (!bus_req) gap_cnt++;
      else begin
        check(gap_cnt == GAP, "R3", "poll gap length", gap_cnt, GAP);
        gap_on = 0;
      end
    end
    if (bus_ack) begin
      bus_ack = 0;
      bus_err = 0;
      acc_idx++;
      lat_cnt = 0;
    end else if (bus_req) begin
      if (lat_cnt < cfg_lat) lat_cnt++;
      else begin
        acc_t e;
        bit flag;
        if (acc_q.size() == 0) begin
          check(0, "R7", "unexpected access addr", bus_addr, 0);
        end else begin
          e = acc_q.pop_front();
          check(bus_addr == e.addr && bus_we == e.we, "R2", "access addr/dir",
                {23'd0, bus_we, bus_addr}, {23'd0, e.we, e.addr});
          if (e.we) check(bus_wdata == e.data, "R2", "write data", bus_wdata, e.data);
        end
        bus_err = (acc_idx == cfg_err_at);
        bus_rdata = 8'h00;
        if (!bus_we && bus_addr == 8'h02) begin
          poll_seen++;
          flag = (poll_seen > cfg_ready_after);
          bus_rdata = flag ? 8'h43 : 8'h41;
          if (!flag && !bus_err && poll_seen < LIMIT) begin
            gap_on = 1;
            gap_cnt = 0;
          end
        end else if (!bus_we && bus_addr >= 8'h31 && bus_addr <= 8'h34) begin
          bus_rdata = cfg_resp[8*(bus_addr-8'h31) +: 8];
        end
        bus_ack = 1;
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (prev_done && done) check(0, "R8", "done longer than one cycle", 1, 0);
    if (done) begin
      res_t r;
      finished = 1;
      if (res_q.size() == 0) check(0, "R8", "unexpected done", 1, 0);
      else begin
        r = res_q.pop_front();
        check(err_code == r.err, "R7", "result code", {30'd0, err_code}, {30'd0, r.err});
        if (r.chk_data) check(resp_data == r.data, "R5", "response word", resp_data, r.data);
      end
    end
    prev_done = done;
  end

  int  exp_idx;
  bit  stopped;

  function automatic void push_acc(input logic [7:0] a, input logic w, input logic [7:0] d);
    acc_t e;
    if (stopped) return;
    e.addr = a; e.we = w; e.data = d;
    acc_q.push_back(e);
    if (exp_idx == cfg_err_at) stopped = 1;
    exp_idx++;
  endfunction

  task automatic run_txn(input logic [7:0] cmd, input bit rd, input logic [31:0] arg,
                         input int ready_after, input int err_at, input int lat,
                         input logic [31:0] resp, input bit poke_busy);
    res_t r;
    bit   flagged;
    logic [31:0] held;
    logic [1:0]  held_err;
    while (!start_ready) @(negedge clk);
    cfg_ready_after = ready_after; cfg_err_at = err_at; cfg_lat = lat; cfg_resp = resp;
    acc_idx = 0; poll_seen = 0; finished = 0;
    exp_idx = 0; stopped = 0; flagged = 0;
    // expected accesses, in order
    push_acc(8'h3F, 1, 8'h80);
    push_acc(8'h38, 1, cmd);
    for (int i = 0; i < 4; i++) push_acc(8'h39 + 8'(i), 1, arg[8*i +: 8]);
    push_acc(8'h40, 1, 8'h01);
    for (int k = 1; k <= LIMIT; k++) begin
      push_acc(8'h02, 0, 8'h00);
      if (stopped) break;
      if (k > ready_after) begin flagged = 1; break; end
    end
    if (flagged && !stopped) begin
      if (rd) for (int i = 0; i < 4; i++) push_acc(8'h31 + 8'(i), 0, 8'h00);
      push_acc(8'h02, 1, 8'h43);
    end
    r.err = stopped ? 2'd1 : (flagged ? 2'd0 : 2'd2);
    r.chk_data = (r.err == 2'd0);
    r.data = rd ? resp : 32'd0;
    res_q.push_back(r);
    // drive start
    cmd_code = cmd; cmd_is_read = rd; cmd_arg = arg; start_valid = 1;
    @(negedge clk);
    start_valid = 0;
    check(!start_ready, "R1", "ready drops after start", start_ready, 0);
    if (poke_busy) begin
      cmd_code = 8'h04; cmd_arg = 32'hFFFF_FFFF; start_valid = 1;
      repeat (3) @(negedge clk);
      start_valid = 0;
      check(!start_ready, "R1", "ready low while busy", start_ready, 0);
    end
    while (!finished) @(negedge clk);
    held = resp_data; held_err = err_code;
    repeat (6) @(negedge clk);
    check(acc_q.size() == 0, "R4", "missing accesses", acc_q.size(), 0);
    check(!bus_req, "R7", "port quiet after done", bus_req, 0);
    check(resp_data == held && err_code == held_err, "R8", "result held",
          resp_data, held);
    check(start_ready, "R1", "idle after done", start_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(start_ready == 1 && done == 0 && bus_req == 0, "R1", "reset state",
          {29'd0, start_ready, done, bus_req}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    // R5: read, flag on first poll, response assembly
    run_txn(8'h01, 1, 32'h0000_0000, 0, -1, 0, 32'hA1B2_C3D4, 0);
    // R2/R3/R6: write command, three misses, slow target, busy start ignored
    run_txn(8'h02, 0, 32'h1234_5678, 3, -1, 2, 32'hDEAD_BEEF, 1);
    // R9: flag on the last allowed read succeeds
    run_txn(8'h03, 1, 32'h0BAD_F00D, LIMIT - 1, -1, 1, 32'h5566_7788, 0);
    // R4: silent target times out
    run_txn(8'h04, 1, 32'h0000_0001, 99, -1, 0, 32'h0, 0);
    // R7: error on an argument write
    run_txn(8'h02, 0, 32'hCAFE_0001, 0, 2, 0, 32'h0, 0);
    // R9: error on the last allowed poll read wins over timeout
    run_txn(8'h03, 1, 32'h0, 99, 7 + LIMIT - 1, 0, 32'h0, 0);
    // R7: error while gathering response
    run_txn(8'h01, 1, 32'h0, 1, 7 + 2 + 2, 1, 32'h0102_0304, 0);
    // R6/R7: error on the clearing write
    run_txn(8'h02, 0, 32'h0000_00FF, 0, 8, 0, 32'h0, 0);
    // R5: read after errors, fresh data
    run_txn(8'h03, 1, 32'hFFFF_0000, 2, -1, 0, 32'h8000_0001, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule